// File: doc/BRIEF.md
# Multiply-Divide Unit with Result Register Pair

This block performs 32x32 multiplication and division, signed or unsigned, for an integer pipeline. Results land in a dedicated pair of 32-bit result registers, called HI and LO, rather than in the general register file. A multiply puts the upper half of its 64-bit product in HI and the lower half in LO. A divide puts the quotient in LO and the remainder in HI.

An operation starts on a one-cycle start strobe that carries a 6-bit function code and two operands. Multiplication is combinational and is written into the pair at the accepting clock edge. Division uses an iterative restoring algorithm that produces one quotient bit per cycle, followed by one cycle for sign correction. During a divide the unit raises a busy flag.

A separate read port serves move-from-HI and move-from-LO. A read that arrives while busy is high gets a stall indication instead of an acknowledge, and it is served once busy falls.

Top module: `muldiv_unit`

## Requirements
- R1: Function code 0x18 (signed multiply), once accepted, writes bits 63..32 of the two's-complement product to HI and bits 31..0 to LO at the accepting edge. Busy stays low.
- R2: Function code 0x19 (unsigned multiply) writes the unsigned 64-bit product in the same way and with the same timing as R1.
- R3: Function code 0x1A (signed divide) writes the quotient, truncated toward zero, to LO and the remainder to HI. The remainder carries the sign of the dividend. The most negative value divided by -1 gives LO = 0x80000000 and HI = 0.
- R4: Function code 0x1B (unsigned divide) writes the unsigned quotient to LO and the unsigned remainder to HI.
- R5: Busy rises at the edge that accepts a divide and stays high for exactly 33 cycles. HI and LO take the divide result at the edge where busy falls and keep their old contents before that edge.
- R6: A divide with a zero divisor completes with the normal timing and writes all ones to LO and the unmodified dividend to HI.
- R7: A start strobe that arrives while busy is high is ignored. It changes neither the result nor the busy timing of the divide in flight.
- R8: A read with function code 0x10 returns HI and one with 0x12 returns LO, with contents unchanged. The acknowledge is high only for these two codes while busy is low.
- R9: A read request while busy is high raises the stall output and holds the acknowledge low until busy falls.
- R10: After reset, HI and LO read as zero and busy is low.
- R11: A start strobe with any function code other than 0x18 to 0x1B leaves HI, LO and busy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for an operation |
| func_i | input | 6 | Function code for the operation |
| opa_i | input | 32 | First operand (multiplicand or dividend) |
| opb_i | input | 32 | Second operand (multiplier or divisor) |
| busy_o | output | 1 | High while a divide is in flight |
| rd_req_i | input | 1 | Read request for HI or LO |
| rd_func_i | input | 6 | Read function code: 0x10 selects HI, 0x12 selects LO |
| rd_data_o | output | 32 | Selected register contents |
| rd_ack_o | output | 1 | Read served this cycle |
| rd_stall_o | output | 1 | Read must wait because busy is high |

## Verification
Multiply and divide run on random operands and on sign-boundary operands: the most negative value with -1 and with 1, mixed-sign small values, all-ones operands, and zero divisors with dividends of both signs. Mixed-sign cases separate signed from unsigned handling and distinguish truncation toward zero from flooring. The min/-1 pair exposes a failure to wrap the negated quotient. Zero divisors show whether the special-case result overrides the sign fixup. Strobes issued mid-divide, strobes with unused codes, and reads held across a divide separate correct interlock behaviour from early or late release of HI and LO.

// File: rtl/md_pkg.sv
package md_pkg;

  typedef enum logic [5:0] {
    FN_MFHI  = 6'h10,
    FN_MFLO  = 6'h12,
    FN_MULT  = 6'h18,
    FN_MULTU = 6'h19,
    FN_DIV   = 6'h1A,
    FN_DIVU  = 6'h1B
  } md_fn_e;

  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_MUL,
    KIND_DIV
  } md_kind_e;

  function automatic md_kind_e fn_kind(input logic [5:0] f);
    case (f)
      FN_MULT, FN_MULTU: fn_kind = KIND_MUL;
      FN_DIV, FN_DIVU:   fn_kind = KIND_DIV;
      default:           fn_kind = KIND_NONE;
    endcase
  endfunction

  // Even codes of the arithmetic group are the signed flavours
  function automatic logic fn_is_signed(input logic [5:0] f);
    fn_is_signed = ~f[0];
  endfunction

endpackage

// File: rtl/md_mult.sv
module md_mult #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           sgn_i,
  output logic [2*W-1:0] prod_o
);
  localparam int PW = 2 * W;

  function automatic logic [PW-1:0] widen(input logic [W-1:0] v, input logic s);
    widen = {{W{s & v[W-1]}}, v};
  endfunction

  // Product of the widened operands, kept to 2W bits, is exact for both flavours
  function automatic logic [PW-1:0] full_product(input logic [W-1:0] a,
                                                 input logic [W-1:0] b,
                                                 input logic s);
    full_product = widen(a, s) * widen(b, s);
  endfunction

  assign prod_o = full_product(a_i, b_i, sgn_i);
endmodule

// File: rtl/md_div.sv
module md_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic         sgn_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         dbz_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] STEPS = CW'(W);

  typedef struct packed {
    logic [W:0]   rem;
    logic [W-1:0] quo;
  } div_state_t;

  function automatic logic [W-1:0] magnitude(input logic [W-1:0] v, input logic s);
    magnitude = (s && v[W-1]) ? (~v + 1'b1) : v;
  endfunction

  // One restoring step: shift in the next dividend bit, subtract when it fits
  function automatic div_state_t restore_step(input div_state_t st, input logic [W-1:0] d);
    logic [W:0] shifted;
    logic [W:0] trial;
    div_state_t nx;
    shifted = {st.rem[W-1:0], st.quo[W-1]};
    trial   = shifted - {1'b0, d};
    nx.rem  = trial[W] ? shifted : trial;
    nx.quo  = {st.quo[W-2:0], ~trial[W]};
    restore_step = nx;
  endfunction

  logic          active;
  logic [CW-1:0] cnt;
  div_state_t    st;
  logic [W-1:0]  dvs_mag;
  logic [W-1:0]  dvd_raw;
  logic          neg_q, neg_r, dbz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      st      <= '0;
      dvs_mag <= '0;
      dvd_raw <= '0;
      neg_q   <= 1'b0;
      neg_r   <= 1'b0;
      dbz     <= 1'b0;
    end else if (!active) begin
      if (go_i) begin
        active  <= 1'b1;
        cnt     <= STEPS;
        st.rem  <= '0;
        st.quo  <= magnitude(dvd_i, sgn_i);
        dvs_mag <= magnitude(dvs_i, sgn_i);
        dvd_raw <= dvd_i;
        neg_q   <= sgn_i & (dvd_i[W-1] ^ dvs_i[W-1]);
        neg_r   <= sgn_i & dvd_i[W-1];
        dbz     <= (dvs_i == '0);
      end
    end else if (cnt != '0) begin
      st  <= restore_step(st, dvs_mag);
      cnt <= cnt - 1'b1;
    end else begin
      active <= 1'b0;
    end
  end

  assign busy_o = active;
  assign done_o = active && (cnt == '0);
  assign dbz_o  = dbz;
  assign quo_o  = dbz ? '1 : (neg_q ? (~st.quo + 1'b1) : st.quo);
  assign rem_o  = dbz ? dvd_raw : (neg_r ? (~st.rem[W-1:0] + 1'b1) : st.rem[W-1:0]);

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt != '0) |=> (active && cnt == CW'($past(cnt) - 1'b1)));
  // R5
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
  // R7
  no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && go_i && cnt != STEPS) |=> (cnt != STEPS));
endmodule

// File: rtl/md_hilo.sv
module md_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_hi_i,
  input  logic [W-1:0] wr_lo_i,
  input  logic         busy_i,
  input  logic         rd_req_i,
  input  logic [5:0]   rd_func_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] rd_data_o,
  output logic         rd_ack_o,
  output logic         rd_stall_o
);
  import md_pkg::*;

  logic [W-1:0] hi_q, lo_q;
  logic         sel_hi, sel_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (wr_en_i) begin
      hi_q <= wr_hi_i;
      lo_q <= wr_lo_i;
    end
  end

  assign sel_hi     = (rd_func_i == FN_MFHI);
  assign sel_lo     = (rd_func_i == FN_MFLO);
  assign rd_stall_o = rd_req_i && busy_i;
  assign rd_ack_o   = rd_req_i && !busy_i && (sel_hi || sel_lo);
  assign rd_data_o  = sel_hi ? hi_q : (sel_lo ? lo_q : '0);
  assign hi_o       = hi_q;
  assign lo_o       = lo_q;

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> ($stable(hi_q) && $stable(lo_q)));
  // R9
  stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stall_o && rd_ack_o));
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [5:0]   func_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         busy_o,
  input  logic         rd_req_i,
  input  logic [5:0]   rd_func_i,
  output logic [W-1:0] rd_data_o,
  output logic         rd_ack_o,
  output logic         rd_stall_o
);
  import md_pkg::*;

  localparam int PW = 2 * W;

  md_kind_e     kind;
  logic         sgn;
  logic         accept, mul_fire, div_fire;
  logic [PW-1:0] prod;
  logic         div_busy, div_done, div_dbz;
  logic [W-1:0] div_q, div_r;
  logic         wr_en;
  logic [W-1:0] wr_hi, wr_lo;
  logic [W-1:0] hi, lo;

  assign kind     = fn_kind(func_i);
  assign sgn      = fn_is_signed(func_i);
  assign accept   = start_i && !div_busy;
  assign mul_fire = accept && (kind == KIND_MUL);
  assign div_fire = accept && (kind == KIND_DIV);

  md_mult #(.W(W)) u_mult (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .sgn_i  (sgn),
    .prod_o (prod)
  );

  md_div #(.W(W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (div_fire),
    .sgn_i  (sgn),
    .dvd_i  (opa_i),
    .dvs_i  (opb_i),
    .busy_o (div_busy),
    .done_o (div_done),
    .dbz_o  (div_dbz),
    .quo_o  (div_q),
    .rem_o  (div_r)
  );

  assign wr_en = mul_fire || div_done;
  assign wr_hi = mul_fire ? prod[PW-1:W] : div_r;
  assign wr_lo = mul_fire ? prod[W-1:0]  : div_q;

  md_hilo #(.W(W)) u_hilo (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en),
    .wr_hi_i    (wr_hi),
    .wr_lo_i    (wr_lo),
    .busy_i     (div_busy),
    .rd_req_i   (rd_req_i),
    .rd_func_i  (rd_func_i),
    .hi_o       (hi),
    .lo_o       (lo),
    .rd_data_o  (rd_data_o),
    .rd_ack_o   (rd_ack_o),
    .rd_stall_o (rd_stall_o)
  );

  assign busy_o = div_busy;

  // R1
  mul_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mul_fire |=> ({hi, lo} == $past(prod)));
  // R5
  div_busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_fire |=> busy_o);
  // R6
  dbz_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_done && div_dbz) |=> (lo == '1));
  // R11
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && kind == KIND_NONE) |=> (!busy_o && $stable(hi) && $stable(lo)));
endmodule

// File: tb/muldiv_unit_bench.sv
module muldiv_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  func_i = '0;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic        busy_o;
  logic        rd_req_i = 1'b0;
  logic [5:0]  rd_func_i = '0;
  logic [31:0] rd_data_o;
  logic        rd_ack_o, rd_stall_o;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  muldiv_unit u_muldiv_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .func_i(func_i),
    .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o),
    .rd_req_i(rd_req_i), .rd_func_i(rd_func_i), .rd_data_o(rd_data_o),
    .rd_ack_o(rd_ack_o), .rd_stall_o(rd_stall_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference arithmetic written from the requirements: {HI, LO}
  function automatic logic [63:0] ref_res(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    logic [63:0] ua, ub;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = {32'd0, a};
    ub = {32'd0, b};
    case (f)
      6'h18: ref_res = 64'(sa * sb);
      6'h19: ref_res = ua * ub;
      6'h1A: begin
        if (b == 0) ref_res = {a, 32'hFFFF_FFFF};
        else begin
          q = sa / sb;
          r = sa % sb;
          ref_res = {r[31:0], q[31:0]};
        end
      end
      6'h1B: begin
        if (b == 0) ref_res = {a, 32'hFFFF_FFFF};
        else ref_res = {32'(ua % ub), 32'(ua / ub)};
      end
      default: ref_res = 64'd0;
    endcase
  endfunction

  // Cycle model: busy countdown and the pair as the bench expects it
  int          m_cnt;
  logic [31:0] m_hi, m_lo;
  logic [63:0] m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_hi <= '0; m_lo <= '0; m_pend <= '0;
    end else if (m_cnt > 0) begin
      m_cnt <= m_cnt - 1;
      if (m_cnt == 1) {m_hi, m_lo} <= m_pend;
    end else if (start_i) begin
      if (func_i == 6'h18 || func_i == 6'h19) {m_hi, m_lo} <= ref_res(func_i, opa_i, opb_i);
      else if (func_i == 6'h1A || func_i == 6'h1B) begin
        m_cnt  <= 33;
        m_pend <= ref_res(func_i, opa_i, opb_i);
      end
    end
  end

  // Per-cycle comparison, one time unit after each rising edge
  always @(posedge clk) begin
    #1;
    cycles++;
    if (rst_n) begin
      bit exp_busy, exp_ack;
      exp_busy = (m_cnt != 0);
      exp_ack  = rd_req_i && !exp_busy && (rd_func_i == 6'h10 || rd_func_i == 6'h12);
      chk(busy_o == exp_busy, "R5 busy", 32'(busy_o), 32'(exp_busy));
      chk(rd_stall_o == (rd_req_i && exp_busy), "R9 stall", 32'(rd_stall_o), 32'(rd_req_i && exp_busy));
      chk(rd_ack_o == exp_ack, "R8 ack", 32'(rd_ack_o), 32'(exp_ack));
      if (exp_ack)
        chk(rd_data_o == (rd_func_i == 6'h10 ? m_hi : m_lo), "R8 data", rd_data_o,
            (rd_func_i == 6'h10 ? m_hi : m_lo));
    end
  end

  task automatic read_pair(input logic [31:0] eh, input logic [31:0] el, input string req);
    @(negedge clk);
    rd_req_i = 1'b1; rd_func_i = 6'h10;
    #1 chk(rd_ack_o && rd_data_o == eh, {req, " HI"}, rd_data_o, eh);
    rd_func_i = 6'h12;
    #1 chk(rd_ack_o && rd_data_o == el, {req, " LO"}, rd_data_o, el);
    @(negedge clk);
    rd_req_i = 1'b0;
  endtask

  task automatic run_op(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b, input string req);
    logic [63:0] e;
    e = ref_res(f, a, b);
    @(negedge clk);
    start_i = 1'b1; func_i = f; opa_i = a; opb_i = b;
    @(negedge clk);
    start_i = 1'b0;
    while (busy_o) @(negedge clk);
    read_pair(e[63:32], e[31:0], req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk(busy_o == 1'b0, "R10 busy", 32'(busy_o), 32'd0);
    read_pair(32'd0, 32'd0, "R10");

    // R1 / R2 multiplies
    run_op(6'h18, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 -1*-1");
    run_op(6'h18, 32'h8000_0000, 32'h8000_0000, "R1 min*min");
    run_op(6'h18, 32'h8000_0000, 32'h0000_0003, "R1 min*3");
    run_op(6'h19, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 max*max");
    run_op(6'h19, 32'h8000_0000, 32'h0000_0002, "R2 carry");
    // R3 signed divides
    run_op(6'h1A, 32'h8000_0000, 32'hFFFF_FFFF, "R3 min/-1");
    run_op(6'h1A, 32'h8000_0000, 32'h0000_0001, "R3 min/1");
    run_op(6'h1A, 32'hFFFF_FFF9, 32'h0000_0002, "R3 -7/2");
    run_op(6'h1A, 32'h0000_0007, 32'hFFFF_FFFE, "R3 7/-2");
    run_op(6'h1A, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R3 -7/-2");
    // R4 unsigned divides
    run_op(6'h1B, 32'hFFFF_FFF9, 32'h0000_0002, "R4 big/2");
    run_op(6'h1B, 32'h0000_0005, 32'h0000_0009, "R4 small/big");
    run_op(6'h1B, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 equal");
    // R6 zero divisor
    run_op(6'h1A, 32'hFFFF_FF00, 32'h0, "R6 neg/0");
    run_op(6'h1A, 32'h0000_1234, 32'h0, "R6 pos/0");
    run_op(6'h1B, 32'h8765_4321, 32'h0, "R6 u/0");

    // R7 strobe during a divide; R9 read held across it
    begin
      logic [63:0] e;
      e = ref_res(6'h1A, 32'd1000, 32'd7);
      @(negedge clk);
      start_i = 1'b1; func_i = 6'h1A; opa_i = 32'd1000; opb_i = 32'd7;
      @(negedge clk);
      start_i = 1'b0;
      rd_req_i = 1'b1; rd_func_i = 6'h12;
      #1 chk(rd_stall_o && !rd_ack_o, "R9 stalled", 32'(rd_stall_o), 32'd1);
      repeat (5) @(negedge clk);
      start_i = 1'b1; func_i = 6'h18; opa_i = 32'd3; opb_i = 32'd5;
      @(negedge clk);
      start_i = 1'b1; func_i = 6'h1B; opa_i = 32'd9; opb_i = 32'd2;
      @(negedge clk);
      start_i = 1'b0;
      while (busy_o) @(negedge clk);
      #1 chk(rd_ack_o && rd_data_o == e[31:0], "R9 released", rd_data_o, e[31:0]);
      rd_req_i = 1'b0;
      read_pair(e[63:32], e[31:0], "R7 ignored");
    end

    // R11 unused codes leave the pair alone
    begin
      logic [63:0] e;
      e = ref_res(6'h1A, 32'd1000, 32'd7);
      foreach (e[k]) if (k < 3) begin
        @(negedge clk);
        start_i = 1'b1; func_i = (k == 0) ? 6'h10 : ((k == 1) ? 6'h20 : 6'h1C);
        opa_i = 32'hDEAD_BEEF; opb_i = 32'h1;
        @(negedge clk);
        start_i = 1'b0;
        #1 chk(!busy_o, "R11 busy", 32'(busy_o), 32'd0);
      end
      read_pair(e[63:32], e[31:0], "R11 pair");
      // R8 non-read code gives no acknowledge
      @(negedge clk);
      rd_req_i = 1'b1; rd_func_i = 6'h11;
      #1 chk(!rd_ack_o, "R8 bad code", 32'(rd_ack_o), 32'd0);
      rd_req_i = 1'b0;
    end

    // Random operands, all four operations
    for (int i = 0; i < 60; i++) begin
      logic [5:0] f;
      f = 6'h18 + 6'(i % 4);
      run_op(f, $urandom, (i % 7 == 0) ? 32'($urandom % 16) : $urandom,
             (f[1] ? (f[0] ? "R4 random" : "R3 random") : (f[0] ? "R2 random" : "R1 random")));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule